// File: doc/BRIEF.md
# Circular Receive-Buffer DMA Address Engine

This block produces write addresses for one receive DMA channel that drops serial bytes into a ring buffer in memory. Incoming bytes are staged in a small FIFO. The engine presents one byte at a time on a request/acknowledge write port. The 24-bit bus address is an 8-bit segment placed above a 16-bit running pointer. The pointer advances by one for every acknowledged write. When the advanced value equals the bound register, the pointer returns to a 256-byte-aligned base instead, and the segment is left as it is.

Software sets up the channel through a small write/read register port. Writing the control register with its enable bit set starts a transfer. The start loads a running counter from the byte-count register. When that counter reaches zero, the channel raises a done flag and stops requesting the bus. An idle-character countdown is reloaded on every accepted byte and counts on a prescaled tick while the channel is enabled. When it expires, it raises a timeout flag, so that software can collect a partial block. Each flag has its own interrupt enable, and both feed one interrupt output.

Top module: `cdw_top`

## Requirements
- R1: `mem_addr[23:16]` always equals the segment register (offset 1) and is never changed by pointer movement; `mem_addr[15:0]` is the pointer register (offset 4).
- R2: Each cycle with `mem_req` and `mem_ack` both high moves the pointer to pointer+1 (modulo 2^16), unless R3 applies.
- R3: If pointer+1 equals the bound register (offset 3), the pointer is loaded instead with the base register (offset 2, 8 bits) in bits 15..8 and zero in bits 7..0.
- R4: Writing offset 0 with bit0=1 loads the remaining-byte counter from the count register (offset 5) and clears the done flag. Each acknowledged write decrements the counter, and a read of offset 5 returns it.
- R5: Once `mem_req` is high without `mem_ack`, it stays high with `mem_addr` and `mem_data` unchanged until acknowledged, unless software writes a register in that cycle.
- R6: Bytes are staged in a 4-entry FIFO and written to memory in arrival order. `in_ready` is low while the FIFO is full. The status register (offset 7) shows full in bit2 and empty in bit3.
- R7: When the remaining counter reaches zero, the done flag (status bit0) sets and no further request is made. A start with count 0 makes no request and does not set done.
- R8: The idle timer reloads from offset 6 on every accepted byte and on start. It decrements once every TICK_DIV (4) cycles while enabled, and setting status bit1 when it steps from 1 to 0. A reload value of 0 never expires.
- R9: `irq` is high when done is set and control bit1 is set, or when timeout is set and control bit2 is set. Writing 1 to a status bit clears that flag, but a flag set in the same cycle wins.
- R10: `in_ready` is low while control bit0 (enable) is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset for write and read |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| in_valid | input | 1 | Received byte is present |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Byte is accepted this cycle when high with `in_valid` |
| mem_req | output | 1 | Memory write request |
| mem_ack | input | 1 | Memory write accepted |
| mem_addr | output | 24 | Write address: segment and pointer |
| mem_data | output | 8 | Byte to write |
| irq | output | 1 | Combined enabled interrupt flags |

## Verification
On every cycle, assertions check four things. The request must hold steady while unacknowledged. The segment must survive each transfer. The pointer must either step by one or land on the base exactly when it meets the bound. A request is never made from an empty FIFO or after done. The arithmetic of whole transfers needs the bench scenarios: it sweeps several segment, base, bound and start-pointer settings, including a one-byte ring and a wrap across the top of the 64 KiB page. Those scenarios also cover done and counter read-back, the exact cycle on which the idle timer expires, interrupt masking and clearing, and FIFO back-pressure, none of which a single-cycle property can show.

// File: rtl/cdw_pkg.sv
package cdw_pkg;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_SEG   = 3'd1,
        REG_BASE  = 3'd2,
        REG_BOUND = 3'd3,
        REG_PTR   = 3'd4,
        REG_COUNT = 3'd5,
        REG_TMO   = 3'd6,
        REG_STAT  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic tmo_ie;
        logic done_ie;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/cdw_ptr_step.sv
module cdw_ptr_step #(
    parameter int unsigned PTR_W  = 16,
    parameter int unsigned BASE_W = 8
) (
    input  logic [PTR_W-1:0]  ptr,
    input  logic [PTR_W-1:0]  bound,
    input  logic [BASE_W-1:0] base,
    output logic [PTR_W-1:0]  ptr_nxt
);
    localparam int unsigned LOW_W = PTR_W - BASE_W;

    logic [PTR_W-1:0] inc;

    always_comb begin
        inc = ptr + PTR_W'(1);
        if (inc == bound) begin
            ptr_nxt = {base, {LOW_W{1'b0}}};
        end else begin
            ptr_nxt = inc;
        end
    end
endmodule

// File: rtl/cdw_fifo.sv
module cdw_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int unsigned IDX_W  = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int unsigned FILL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [IDX_W-1:0]        wr;
        logic [IDX_W-1:0]        rd;
        logic [FILL_W-1:0]       fill;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  push_ok, pop_ok;

    assign full  = (f_q.fill == FILL_W'(DEPTH));
    assign empty = (f_q.fill == '0);
    assign head  = f_q.mem[f_q.rd];

    always_comb begin
        f_d     = f_q;
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (push_ok) begin
            f_d.mem[f_q.wr] = push_data;
            f_d.wr = (f_q.wr == IDX_W'(DEPTH - 1)) ? '0 : f_q.wr + IDX_W'(1);
        end
        if (pop_ok) begin
            f_d.rd = (f_q.rd == IDX_W'(DEPTH - 1)) ? '0 : f_q.rd + IDX_W'(1);
        end
        if (push_ok && !pop_ok) begin
            f_d.fill = f_q.fill + FILL_W'(1);
        end else if (pop_ok && !push_ok) begin
            f_d.fill = f_q.fill - FILL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end
endmodule

// File: rtl/cdw_idle_timer.sv
module cdw_idle_timer #(
    parameter int unsigned TMO_W    = 8,
    parameter int unsigned TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    input  logic [TMO_W-1:0] reload_val,
    output logic             expire
);
    localparam int unsigned PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [TMO_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic tick;

    assign tick   = run && !reload && (t_q.pre == PRE_LAST);
    assign expire = tick && (t_q.cnt == TMO_W'(1));

    always_comb begin
        t_d = t_q;
        if (reload) begin
            t_d.pre = '0;
            t_d.cnt = reload_val;
        end else if (run) begin
            if (tick) begin
                t_d.pre = '0;
                if (t_q.cnt != '0) begin
                    t_d.cnt = t_q.cnt - TMO_W'(1);
                end
            end else begin
                t_d.pre = t_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end
endmodule

// File: rtl/cdw_top.sv
module cdw_top
    import cdw_pkg::*;
#(
    parameter int unsigned SEG_W      = 8,
    parameter int unsigned PTR_W      = 16,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned TMO_W      = 8,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned REG_DW     = 16,
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned TICK_DIV   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [2:0]              cfg_addr,
    input  logic [REG_DW-1:0]       cfg_wdata,
    output logic [REG_DW-1:0]       cfg_rdata,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_data,
    output logic                    in_ready,
    output logic                    mem_req,
    input  logic                    mem_ack,
    output logic [SEG_W+PTR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]       mem_data,
    output logic                    irq
);
    localparam int unsigned BASE_W = PTR_W - 8;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [SEG_W-1:0]  seg;
        logic [BASE_W-1:0] base;
        logic [PTR_W-1:0]  bound;
        logic [PTR_W-1:0]  ptr;
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  remain;
        logic [TMO_W-1:0]  tmo;
        logic              done;
        logic              tmo_flag;
    } chan_t;

    chan_t s_d, s_q;

    logic              fifo_full, fifo_empty;
    logic [DATA_W-1:0] fifo_head;
    logic [PTR_W-1:0]  ptr_nxt;
    logic              accept, xfer, start, expire;
    logic [PTR_W-1:0]  bound_q;
    logic [BASE_W-1:0] base_q;
    logic              done_q;

    assign start    = cfg_we && (reg_sel_e'(cfg_addr) == REG_CTRL) && cfg_wdata[0];
    assign in_ready = s_q.ctrl.en && !fifo_full;
    assign accept   = in_valid && in_ready;
    assign mem_req  = s_q.ctrl.en && !fifo_empty && (s_q.remain != '0);
    assign xfer     = mem_req && mem_ack;
    assign mem_addr = {s_q.seg, s_q.ptr};
    assign mem_data = fifo_head;
    assign irq      = (s_q.done && s_q.ctrl.done_ie) || (s_q.tmo_flag && s_q.ctrl.tmo_ie);
    assign bound_q  = s_q.bound;
    assign base_q   = s_q.base;
    assign done_q   = s_q.done;

    cdw_fifo #(
        .W     (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_data (in_data),
        .pop       (xfer),
        .head      (fifo_head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    cdw_ptr_step #(
        .PTR_W  (PTR_W),
        .BASE_W (BASE_W)
    ) i_step (
        .ptr     (s_q.ptr),
        .bound   (s_q.bound),
        .base    (s_q.base),
        .ptr_nxt (ptr_nxt)
    );

    cdw_idle_timer #(
        .TMO_W    (TMO_W),
        .TICK_DIV (TICK_DIV)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (s_q.ctrl.en),
        .reload     (accept || start),
        .reload_val (s_q.tmo),
        .expire     (expire)
    );

    always_comb begin
        s_d = s_q;
        // flag clears first so that a same-cycle set wins
        if (cfg_we && (reg_sel_e'(cfg_addr) == REG_STAT)) begin
            if (cfg_wdata[0]) s_d.done     = 1'b0;
            if (cfg_wdata[1]) s_d.tmo_flag = 1'b0;
        end
        if (xfer) begin
            s_d.ptr    = ptr_nxt;
            s_d.remain = s_q.remain - CNT_W'(1);
            if (s_q.remain == CNT_W'(1)) begin
                s_d.done = 1'b1;
            end
        end
        if (expire) begin
            s_d.tmo_flag = 1'b1;
        end
        if (cfg_we) begin
            case (reg_sel_e'(cfg_addr))
                REG_CTRL: begin
                    s_d.ctrl.en      = cfg_wdata[0];
                    s_d.ctrl.done_ie = cfg_wdata[1];
                    s_d.ctrl.tmo_ie  = cfg_wdata[2];
                    if (cfg_wdata[0]) begin
                        s_d.remain = s_q.count;
                        s_d.done   = 1'b0;
                    end
                end
                REG_SEG:   s_d.seg   = SEG_W'(cfg_wdata);
                REG_BASE:  s_d.base  = BASE_W'(cfg_wdata);
                REG_BOUND: s_d.bound = PTR_W'(cfg_wdata);
                REG_PTR:   s_d.ptr   = PTR_W'(cfg_wdata);
                REG_COUNT: s_d.count = CNT_W'(cfg_wdata);
                REG_TMO:   s_d.tmo   = TMO_W'(cfg_wdata);
                default:   ;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (reg_sel_e'(cfg_addr))
            REG_CTRL:  cfg_rdata = REG_DW'({s_q.ctrl.tmo_ie, s_q.ctrl.done_ie, s_q.ctrl.en});
            REG_SEG:   cfg_rdata = REG_DW'(s_q.seg);
            REG_BASE:  cfg_rdata = REG_DW'(s_q.base);
            REG_BOUND: cfg_rdata = REG_DW'(s_q.bound);
            REG_PTR:   cfg_rdata = REG_DW'(s_q.ptr);
            REG_COUNT: cfg_rdata = REG_DW'(s_q.remain);
            REG_TMO:   cfg_rdata = REG_DW'(s_q.tmo);
            REG_STAT:  cfg_rdata = REG_DW'({fifo_empty, fifo_full, s_q.tmo_flag, s_q.done});
            default:   cfg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/cdw_checker.sv
module cdw_checker #(
    parameter int unsigned SEG_W  = 8,
    parameter int unsigned PTR_W  = 16,
    parameter int unsigned BASE_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic                   mem_req,
    input logic                   mem_ack,
    input logic [SEG_W+PTR_W-1:0] mem_addr,
    input logic [DATA_W-1:0]      mem_data,
    input logic [PTR_W-1:0]       bound_q,
    input logic [BASE_W-1:0]      base_q,
    input logic                   done_q,
    input logic                   fifo_empty
);
    localparam int unsigned ADDR_W = SEG_W + PTR_W;
    localparam int unsigned LOW_W  = PTR_W - BASE_W;

    logic [PTR_W-1:0] cur_ptr;
    logic             hit_bound;

    assign cur_ptr   = mem_addr[PTR_W-1:0];
    assign hit_bound = ((cur_ptr + PTR_W'(1)) == bound_q);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !cfg_we) |=> (mem_req && $stable(mem_addr) && $stable(mem_data))); // R5

    AST_SEG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !cfg_we) |=> (mem_addr[ADDR_W-1:PTR_W] == $past(mem_addr[ADDR_W-1:PTR_W]))); // R1

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !cfg_we && !hit_bound) |=> (cur_ptr == $past(cur_ptr) + PTR_W'(1))); // R2

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !cfg_we && hit_bound) |=> (cur_ptr == {$past(base_q), {LOW_W{1'b0}}})); // R3

    AST_REQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !fifo_empty); // R6

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !mem_req); // R7
endmodule

bind cdw_top cdw_checker #(
    .SEG_W  (SEG_W),
    .PTR_W  (PTR_W),
    .BASE_W (BASE_W),
    .DATA_W (DATA_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .bound_q    (bound_q),
    .base_q     (base_q),
    .done_q     (done_q),
    .fifo_empty (fifo_empty)
);

// File: tb/test_cdw_top.sv
module test_cdw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        mem_req;
    logic        mem_ack = 1'b0;
    logic [23:0] mem_addr;
    logic [7:0]  mem_data;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int n_sent = 0;
    int n_ack = 0;
    int wait_cnt = 0;
    bit holding = 0;
    logic [23:0] hold_addr;
    logic [7:0]  exp_seg = '0;
    logic [7:0]  exp_base = '0;
    logic [15:0] exp_bound = '0;
    logic [15:0] exp_ptr = '0;

    always #5 clk = ~clk;

    cdw_top i_cdw_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .mem_req(mem_req),
        .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
    );

    function automatic logic [7:0] byte_of(input int k);
        return 8'(k * 7 + 3);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic send_byte();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = byte_of(n_sent);
        n_sent++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // memory responder: variable latency, checks address and data arithmetically
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n && mem_req) begin
                if (wait_cnt >= (n_ack % 3)) begin
                    chk(mem_addr == {exp_seg, exp_ptr}, "R1 R2 R3 address", 32'(mem_addr), 32'({exp_seg, exp_ptr}));
                    chk(mem_data == byte_of(n_ack), "R6 order", 32'(mem_data), 32'(byte_of(n_ack)));
                    if (holding)
                        chk(mem_addr == hold_addr, "R5 hold", 32'(mem_addr), 32'(hold_addr));
                    mem_ack = 1'b1;
                    n_ack++;
                    wait_cnt = 0;
                    holding = 0;
                    if (exp_ptr + 16'd1 == exp_bound) exp_ptr = {exp_base, 8'h00};
                    else exp_ptr = exp_ptr + 16'd1;
                end else begin
                    if (holding)
                        chk(mem_addr == hold_addr, "R5 hold", 32'(mem_addr), 32'(hold_addr));
                    hold_addr = mem_addr;
                    holding = 1;
                    wait_cnt++;
                end
            end
        end
    end

    task automatic run_cfg(input logic [7:0] seg, input logic [7:0] base, input logic [15:0] bound,
                           input logic [15:0] ptr, input int count, input bit extra);
        logic [15:0] v;
        int guard;
        exp_seg = seg; exp_base = base; exp_bound = bound; exp_ptr = ptr;
        wr(3'd0, 16'd0);
        wr(3'd1, 16'(seg));
        wr(3'd2, 16'(base));
        wr(3'd3, bound);
        wr(3'd4, ptr);
        wr(3'd5, 16'(count));
        wr(3'd6, 16'd0);
        wr(3'd0, 16'h0003);
        for (int i = 0; i < count; i++) send_byte();
        guard = 0;
        while (!irq && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk(irq == 1'b1, "R7 R9 done irq", 32'(irq), 32'd1);
        rd(3'd7, v);
        chk(v[0] == 1'b1, "R7 done flag", 32'(v), 32'h1);
        rd(3'd5, v);
        chk(v == 16'd0, "R4 remaining", 32'(v), 32'd0);
        rd(3'd4, v);
        chk(v == exp_ptr, "R2 R3 final pointer", 32'(v), 32'(exp_ptr));
        rd(3'd1, v);
        chk(v[7:0] == seg, "R1 segment unchanged", 32'(v), 32'(seg));
        chk(mem_addr[23:16] == seg, "R1 address segment", 32'(mem_addr), 32'(seg));
        if (extra) begin
            send_byte();
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                chk(mem_req == 1'b0, "R7 no request after done", 32'(mem_req), 32'd0);
            end
        end
        wr(3'd7, 16'h0001);
        #1;
        chk(irq == 1'b0, "R9 clear done", 32'(irq), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R7 watchdog actual=hung expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req == 1'b0, "R7 reset request", 32'(mem_req), 32'd0);
        chk(irq == 1'b0, "R9 reset irq", 32'(irq), 32'd0);
        chk(in_ready == 1'b0, "R10 disabled not ready", 32'(in_ready), 32'd0);
        rd(3'd7, v);
        chk(v == 16'h0008, "R6 reset status empty", 32'(v), 32'h8);
        rd(3'd4, v);
        chk(v == 16'h0000, "R1 reset pointer", 32'(v), 32'h0);

        // address sweeps: multi-wrap, wrap across page top, one-byte ring, single wrap
        run_cfg(8'h5A, 8'h12, 16'h1206, 16'h1203, 10, 1'b0);
        run_cfg(8'h00, 8'hFF, 16'h0000, 16'hFFFD, 6, 1'b0);
        run_cfg(8'hFF, 8'h00, 16'h0001, 16'h0000, 4, 1'b0);
        run_cfg(8'h3C, 8'h80, 16'h8040, 16'h8000, 70, 1'b1);
        chk(n_ack == 90, "R4 total writes", 32'(n_ack), 32'd90);

        // count 0: no request, no done; idle timer expiry cycle
        wr(3'd5, 16'd0);
        wr(3'd6, 16'd3);
        wr(3'd0, 16'h0005);
        send_byte();
        chk(mem_req == 1'b0, "R7 count zero no request", 32'(mem_req), 32'd0);
        repeat (11) @(negedge clk);
        chk(irq == 1'b0, "R8 timer before expiry", 32'(irq), 32'd0);
        @(negedge clk);
        chk(irq == 1'b1, "R8 timer expiry cycle", 32'(irq), 32'd1);
        rd(3'd7, v);
        chk(v[1:0] == 2'b10, "R8 R7 status timeout not done", 32'(v), 32'h2);
        wr(3'd7, 16'h0002);
        #1;
        chk(irq == 1'b0, "R9 clear timeout", 32'(irq), 32'd0);
        repeat (40) @(negedge clk);
        chk(irq == 1'b0, "R8 no refire", 32'(irq), 32'd0);

        // timeout with its interrupt disabled
        wr(3'd0, 16'h0001);
        send_byte();
        repeat (20) @(negedge clk);
        chk(irq == 1'b0, "R9 masked timeout", 32'(irq), 32'd0);
        rd(3'd7, v);
        chk(v[1] == 1'b1, "R8 flag while masked", 32'(v), 32'h2);
        wr(3'd7, 16'h0002);

        // reload value 0 never expires; this byte fills the FIFO
        wr(3'd6, 16'd0);
        wr(3'd0, 16'h0005);
        send_byte();
        repeat (100) @(negedge clk);
        chk(irq == 1'b0, "R8 zero reload silent", 32'(irq), 32'd0);
        chk(in_ready == 1'b0, "R6 full not ready", 32'(in_ready), 32'd0);
        rd(3'd7, v);
        chk(v[3:2] == 2'b01, "R6 status full", 32'(v), 32'h4);

        wr(3'd0, 16'h0000);
        #1;
        chk(in_ready == 1'b0, "R10 disabled", 32'(in_ready), 32'd0);

        summary();
        $finish;
    end
endmodule